// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block times an external signal by counting ticks of a selectable count source between edges of that signal. In the two period modes it measures from one edge of a chosen polarity to the next edge of the same polarity. In width mode every edge ends a measurement, so successive results alternate between high-level and low-level widths. A status bit tells software which level the latest result covers.

On each qualifying edge the running count is moved into a capture register and counting restarts. An interrupt request pulse marks each new result. The counter can run past its top value between two edges; when it wraps, a sticky overflow flag is set and an interrupt is raised. Software reads the flag to tell an overflow interrupt from an edge interrupt. To clear the flag, software writes the configuration again while the timer runs, using the same field values. The clear takes effect on the next tick of the selected source.

The first edge after a start only primes the capture register and raises no interrupt. The mode and source fields are locked while the timer runs.

Top module: `pulse_meas_timer`

## Requirements
- R1: After reset the timer is stopped. `capVal`, `capLevel`, `irqReq`, `ovfFlag`, `cfgMeas` and `cfgSrc` are all 0.
- R2: A configuration write is applied only when `runIn` is 0 in that cycle. A write made while running leaves `cfgMeas` and `cfgSrc` unchanged.
- R3: Period modes measure between edges of one polarity. With `cfgMeas` = 0 the timer measures rising to rising; with `cfgMeas` = 1 it measures falling to falling. Edges of the other polarity have no effect. A result equals the number of selected ticks between the two edges, where a tick in the capture cycle counts toward the new interval.
- R4: Width mode (`cfgMeas` = 2 or 3) captures on every edge. `capLevel` is set to the input level that held before the edge: 1 for a high width, 0 for a low width. In all modes `capLevel` follows this rule.
- R5: The first qualifying edge after `runIn` rises loads `capVal` with the count since the start and raises no interrupt.
- R6: Every later capture raises `irqReq` for exactly one cycle. `capVal` is updated in the same cycle.
- R7: When a selected tick finds the counter at 2^CNT_W-1, the counter wraps to 0, `ovfFlag` is set and stays set, and `irqReq` pulses.
- R8: A write with field values equal to `cfgMeas` and `cfgSrc` while running clears `ovfFlag` on the first selected tick after the write. Without such a tick the flag stays set, and while stopped it never changes.
- R9: Only the `tickIn` bit chosen by `cfgSrc` advances the counter.
- R10: While `runIn` is 0, input edges cause no capture and no interrupt.
- R11: If a capture and a wrap fall in the same cycle, `capVal` takes 2^CNT_W-1, `ovfFlag` is set, and a single one-cycle `irqReq` pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeWrEn | input | 1 | Configuration write strobe |
| modeWrMeas | input | 2 | Measurement mode to write: 0 rise-rise, 1 fall-fall, 2/3 width |
| modeWrSrc | input | SEL_W | Count source index to write |
| runIn | input | 1 | Start (1) / stop (0) level |
| tickIn | input | NUM_SRC | Count-enable strobes, one per source |
| measIn | input | 1 | Asynchronous signal under measurement |
| cfgMeas | output | 2 | Current measurement mode |
| cfgSrc | output | SEL_W | Current count source index |
| capVal | output | CNT_W | Latest captured count |
| capLevel | output | 1 | Level measured by the latest capture |
| irqReq | output | 1 | One-cycle interrupt request |
| ovfFlag | output | 1 | Sticky counter overflow flag |

## Verification
A wrong edge qualifier or a wrong counter restart value shows up as a `capVal` that is off by one or more ticks, three cycles after the input edge. That covers two cycles of synchronizer and one cycle of capture. A wrong first-edge or overflow state shows up as a missing or extra `irqReq` pulse in the cycle after the triggering clock edge. The bench counts pulses between stimuli to catch this. A fault in the clear-pending logic only appears at the first selected tick after a write. For that reason the source is held idle across the write, and `ovfFlag` is sampled before and after a single tick.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  typedef enum logic [1:0] {
    MEAS_RISE   = 2'b00,
    MEAS_FALL   = 2'b01,
    MEAS_WIDTH  = 2'b10,
    MEAS_WIDTH2 = 2'b11
  } measSel_e;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic countEn;      // selected tick while running
    logic capture;      // qualifying edge while running
    logic restart;      // first cycle of a run
    logic levelBefore;  // synchronized level before the current edge
  } dpStrobes_t;

endpackage

// File: rtl/ptm_ctrl.sv
module ptm_ctrl
  import ptm_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               modeWrEn,
  input  logic [1:0]         modeWrMeas,
  input  logic [SEL_W-1:0]   modeWrSrc,
  input  logic               runIn,
  input  logic [NUM_SRC-1:0] tickIn,
  input  logic               measIn,
  input  logic               wrapHit,
  output dpStrobes_t         strobes,
  output logic [1:0]         cfgMeas,
  output logic [SEL_W-1:0]   cfgSrc,
  output logic               irqReq,
  output logic               ovfFlag
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic prevLvl;
  logic syncLvl;
  logic runQ;
  logic firstPend;
  logic clrPend;
  logic tickSel;
  logic qualEdge;
  logic riseSeen;
  logic fallSeen;
  logic startNow;
  logic active;
  logic sameCfg;

  // input synchronizer, depth set by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= measIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= {syncChain[SYNC_STAGES-2:0], measIn};
      end
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLvl <= 1'b0;
      runQ    <= 1'b0;
    end else begin
      prevLvl <= syncLvl;
      runQ    <= runIn;
    end
  end

  assign riseSeen = syncLvl & ~prevLvl;
  assign fallSeen = ~syncLvl & prevLvl;
  assign startNow = runIn & ~runQ;
  assign active   = runIn & runQ;

  always_comb begin
    tickSel = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfgSrc == i[SEL_W-1:0]) tickSel = tickIn[i];
    end
  end

  always_comb begin
    unique case (measSel_e'(cfgMeas))
      MEAS_RISE: qualEdge = riseSeen;
      MEAS_FALL: qualEdge = fallSeen;
      default:   qualEdge = riseSeen | fallSeen;
    endcase
  end

  always_comb begin
    strobes.countEn     = active & tickSel;
    strobes.capture     = active & qualEdge;
    strobes.restart     = startNow;
    strobes.levelBefore = prevLvl;
  end

  assign sameCfg = (modeWrMeas == cfgMeas) && (modeWrSrc == cfgSrc);

  // configuration register: locked while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgMeas <= '0;
      cfgSrc  <= '0;
    end else if (modeWrEn && !runIn) begin
      cfgMeas <= modeWrMeas;
      cfgSrc  <= modeWrSrc;
    end
  end

  // first edge after a start only primes the capture register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               firstPend <= 1'b0;
    else if (startNow)        firstPend <= 1'b1;
    else if (strobes.capture) firstPend <= 1'b0;
  end

  // overflow clear waits for the next selected tick after the write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              clrPend <= 1'b0;
    else if (modeWrEn && runIn && sameCfg)   clrPend <= 1'b1;
    else if (clrPend && strobes.countEn)     clrPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ovfFlag <= 1'b0;
    else if (wrapHit)                     ovfFlag <= 1'b1;
    else if (clrPend && strobes.countEn)  ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqReq <= 1'b0;
    else        irqReq <= (strobes.capture & ~firstPend) | wrapHit;
  end

endmodule

// File: rtl/ptm_datapath.sv
module ptm_datapath
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobes_t       strobes,
  output logic [CNT_W-1:0] capVal,
  output logic             capLevel,
  output logic             wrapHit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign wrapHit = strobes.countEn && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobes.restart) begin
      cnt <= '0;
    end else if (strobes.capture) begin
      // a tick coinciding with the edge belongs to the new interval
      cnt <= strobes.countEn ? CNT_ONE : '0;
    end else if (strobes.countEn) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capVal   <= '0;
      capLevel <= 1'b0;
    end else if (strobes.capture) begin
      capVal   <= cnt;
      capLevel <= strobes.levelBefore;
    end
  end

endmodule

// File: rtl/pulse_meas_timer.sv
module pulse_meas_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               modeWrEn,
  input  logic [1:0]         modeWrMeas,
  input  logic [SEL_W-1:0]   modeWrSrc,
  input  logic               runIn,
  input  logic [NUM_SRC-1:0] tickIn,
  input  logic               measIn,
  output logic [1:0]         cfgMeas,
  output logic [SEL_W-1:0]   cfgSrc,
  output logic [CNT_W-1:0]   capVal,
  output logic               capLevel,
  output logic               irqReq,
  output logic               ovfFlag
);

  dpStrobes_t strobes;
  logic       wrapHit;

  ptm_ctrl #(
    .NUM_SRC    (NUM_SRC),
    .SEL_W      (SEL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .modeWrEn  (modeWrEn),
    .modeWrMeas(modeWrMeas),
    .modeWrSrc (modeWrSrc),
    .runIn     (runIn),
    .tickIn    (tickIn),
    .measIn    (measIn),
    .wrapHit   (wrapHit),
    .strobes   (strobes),
    .cfgMeas   (cfgMeas),
    .cfgSrc    (cfgSrc),
    .irqReq    (irqReq),
    .ovfFlag   (ovfFlag)
  );

  ptm_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .capVal  (capVal),
    .capLevel(capLevel),
    .wrapHit (wrapHit)
  );

endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             runIn,
  input logic [1:0]       cfgMeas,
  input logic [SEL_W-1:0] cfgSrc,
  input logic             irqReq,
  input logic             ovfFlag
);

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !runIn |=> !irqReq); // R10

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    runIn |=> $stable({cfgMeas, cfgSrc})); // R2

  AST_OVF_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovfFlag) |-> irqReq); // R7

  AST_START_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(runIn) |=> !irqReq); // R5

  AST_OVF_HELD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !runIn |=> $stable(ovfFlag)); // R8

endmodule

bind pulse_meas_timer ptm_checker #(.SEL_W(SEL_W)) u_ptm_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .runIn  (runIn),
  .cfgMeas(cfgMeas),
  .cfgSrc (cfgSrc),
  .irqReq (irqReq),
  .ovfFlag(ovfFlag)
);

// File: tb/pulse_meas_timer_bench.sv
module pulse_meas_timer_bench;

  localparam int CNT_W   = 10;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = 2;
  localparam int MAXV    = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               modeWrEn = 1'b0;
  logic [1:0]         modeWrMeas = '0;
  logic [SEL_W-1:0]   modeWrSrc = '0;
  logic               runIn = 1'b0;
  logic [NUM_SRC-1:0] tickIn = '0;
  logic               measIn = 1'b0;
  logic [1:0]         cfgMeas;
  logic [SEL_W-1:0]   cfgSrc;
  logic [CNT_W-1:0]   capVal;
  logic               capLevel;
  logic               irqReq;
  logic               ovfFlag;

  int nChk = 0;
  int nFail = 0;
  int irqCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pulse_meas_timer #(
    .CNT_W  (CNT_W),
    .NUM_SRC(NUM_SRC),
    .SEL_W  (SEL_W)
  ) u_pulse_meas_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .modeWrEn  (modeWrEn),
    .modeWrMeas(modeWrMeas),
    .modeWrSrc (modeWrSrc),
    .runIn     (runIn),
    .tickIn    (tickIn),
    .measIn    (measIn),
    .cfgMeas   (cfgMeas),
    .cfgSrc    (cfgSrc),
    .capVal    (capVal),
    .capLevel  (capLevel),
    .irqReq    (irqReq),
    .ovfFlag   (ovfFlag)
  );

  always @(posedge clk) begin
    if (rst_n && irqReq) irqCount <= irqCount + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; modeWrEn = 1'b0; runIn = 1'b0; tickIn = '0; measIn = 1'b0;
    waitN(3);
    rst_n = 1'b1;
    waitN(1);
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic [SEL_W-1:0] s);
    modeWrMeas = m; modeWrSrc = s; modeWrEn = 1'b1;
    waitN(1);
    modeWrEn = 1'b0;
    waitN(1);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 capVal", int'(capVal), 0);
    chk("R1 capLevel", int'(capLevel), 0);
    chk("R1 irqReq", int'(irqReq), 0);
    chk("R1 ovfFlag", int'(ovfFlag), 0);
    chk("R1 cfgMeas", int'(cfgMeas), 0);
    chk("R1 cfgSrc", int'(cfgSrc), 0);
  endtask

  task automatic testWidth();
    int i0;
    doReset();
    writeCfg(2'b10, 2'd0);
    tickIn = 4'b0001;
    runIn = 1'b1;
    i0 = irqCount;
    waitN(5);
    measIn = 1'b1;
    waitN(20);
    chk("R5 first capture value", int'(capVal), 6);
    chk("R5 first capture no irq", irqCount - i0, 0);
    measIn = 1'b0;
    waitN(30);
    chk("R4 high width", int'(capVal), 20);
    chk("R4 level high", int'(capLevel), 1);
    chk("R6 one pulse per capture", irqCount - i0, 1);
    measIn = 1'b1;
    waitN(40);
    chk("R4 low width", int'(capVal), 30);
    chk("R4 level low", int'(capLevel), 0);
    chk("R6 second pulse", irqCount - i0, 2);
  endtask

  task automatic testPeriod();
    int i0;
    doReset();
    writeCfg(2'b00, 2'd0);
    tickIn = 4'b0001;
    runIn = 1'b1;
    waitN(5);
    measIn = 1'b1;
    waitN(7);
    i0 = irqCount;
    measIn = 1'b0;
    waitN(8);
    chk("R3 falling edge ignored in rise mode", irqCount - i0, 0);
    measIn = 1'b1;
    waitN(10);
    chk("R3 rise-rise period", int'(capVal), 15);
    chk("R3 rise mode level", int'(capLevel), 0);
    measIn = 1'b0;
    waitN(12);
    measIn = 1'b1;
    waitN(6);
    chk("R3 second rise-rise period", int'(capVal), 22);
    chk("R6 period irq count", irqCount - i0, 2);
    // falling to falling
    doReset();
    writeCfg(2'b01, 2'd0);
    measIn = 1'b1;
    tickIn = 4'b0001;
    waitN(4);
    runIn = 1'b1;
    waitN(5);
    measIn = 1'b0;
    waitN(4);
    measIn = 1'b1;
    waitN(9);
    measIn = 1'b0;
    waitN(6);
    chk("R3 fall-fall period", int'(capVal), 13);
    chk("R4 fall mode level", int'(capLevel), 1);
  endtask

  task automatic testSource();
    doReset();
    writeCfg(2'b10, 2'd2);
    tickIn = 4'b0001;
    runIn = 1'b1;
    waitN(5);
    measIn = 1'b1;
    waitN(10);
    measIn = 1'b0;
    waitN(10);
    chk("R9 unselected source does not count", int'(capVal), 0);
    runIn = 1'b0;
    waitN(2);
    writeCfg(2'b10, 2'd1);
    chk("R2 write while stopped applied", int'(cfgSrc), 1);
    tickIn = 4'b0010;
    runIn = 1'b1;
    waitN(5);
    measIn = 1'b1;
    waitN(11);
    measIn = 1'b0;
    waitN(6);
    chk("R9 selected source counts", int'(capVal), 11);
  endtask

  task automatic testStop();
    int i0;
    doReset();
    writeCfg(2'b10, 2'd0);
    tickIn = 4'b0001;
    runIn = 1'b1;
    waitN(5);
    measIn = 1'b1;
    waitN(10);
    measIn = 1'b0;
    waitN(10);
    chk("R4 width before stop", int'(capVal), 10);
    writeCfg(2'b00, 2'd3);
    chk("R2 running write ignored meas", int'(cfgMeas), 2);
    chk("R2 running write ignored src", int'(cfgSrc), 0);
    runIn = 1'b0;
    waitN(2);
    i0 = irqCount;
    for (int k = 0; k < 4; k++) begin
      measIn = ~measIn;
      waitN(7);
    end
    chk("R10 no irq while stopped", irqCount - i0, 0);
    chk("R10 no capture while stopped", int'(capVal), 10);
  endtask

  task automatic testOverflow();
    int i0;
    doReset();
    writeCfg(2'b10, 2'd1);
    runIn = 1'b1;
    waitN(3);
    i0 = irqCount;
    tickIn = 4'b0010;
    waitN(MAXV);
    tickIn = '0;
    waitN(3);
    chk("R7 no overflow at top value", int'(ovfFlag), 0);
    tickIn = 4'b0010;
    waitN(1);
    tickIn = '0;
    waitN(3);
    chk("R7 overflow flag set", int'(ovfFlag), 1);
    chk("R7 overflow irq", irqCount - i0, 1);
    writeCfg(2'b10, 2'd1);
    waitN(4);
    chk("R8 flag held without tick", int'(ovfFlag), 1);
    tickIn = 4'b0001;
    waitN(3);
    tickIn = '0;
    chk("R8 unselected tick does not clear", int'(ovfFlag), 1);
    tickIn = 4'b0010;
    waitN(1);
    tickIn = '0;
    waitN(2);
    chk("R8 flag cleared on next tick", int'(ovfFlag), 0);
    measIn = 1'b1;
    waitN(6);
    chk("R7 counter wrapped to zero", int'(capVal), 1);
  endtask

  task automatic testCoincide();
    int i0;
    doReset();
    writeCfg(2'b00, 2'd0);
    tickIn = 4'b0001;
    runIn = 1'b1;
    waitN(5);
    measIn = 1'b1;
    waitN(100);
    measIn = 1'b0;
    waitN(MAXV - 100);
    i0 = irqCount;
    measIn = 1'b1;
    waitN(6);
    chk("R11 capture at top value", int'(capVal), MAXV);
    chk("R11 overflow flag set", int'(ovfFlag), 1);
    chk("R11 single irq pulse", irqCount - i0, 1);
  endtask

  initial begin
    testReset();
    testWidth();
    testPeriod();
    testSource();
    testStop();
    testOverflow();
    testCoincide();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule